// File: doc/BRIEF.md
# Read-After-Write Hazard Cycle Calculator

This block evaluates one source-operand read against the writes that can still delay it. It returns whether the read must wait, how many cycles are left, and which register is responsible. The caller supplies two groups of entries. The first group holds in-flight writes to the register or to its sub-registers. Each in-flight entry carries a signed cycles-left count, an unknown-latency flag, the signed read-advance that applies to this read, the write's register ID and a tag that identifies the write. The second group holds recently written-back writes. Each of these carries its write-back cycle stamp, read-advance and register ID. The caller also supplies the current cycle count. Alias resolution happens before this block.

A read-advance lowers the wait on an in-flight producer. A negative read-advance lengthens it. Because of this, a write that has already retired still stalls the read until enough cycles have passed since its write-back. The block takes the largest positive remaining wait over all entries. If no entry gives a positive known wait, the first unknown-latency producer is reported instead. A one-cycle `start_i` strobe latches the inputs, and the result is registered with a `done_o` pulse one clock later.

Top module: `raw_hazard_calc`

## Requirements
- R1: While `rst_ni` is low and until the first start, `done_o`, `hazard_o` and `unknown_o` are 0, and `cycles_o` and `reg_o` are 0.
- R2: A result computed from the inputs sampled at a clock edge where `start_i` is 1 appears on the outputs after that edge, and `done_o` is 1 for exactly that one cycle. When `start_i` is 0 the result outputs keep their values.
- R3: For an in-flight entry that is valid, known-latency and not a duplicate, the remaining wait is its cycles-left minus its read-advance, both taken as two's complement. Only a result above zero counts. `hazard_o`=1 and `unknown_o`=0 report the largest such value on `cycles_o`, with that entry's register on `reg_o`.
- R4: On equal remaining waits, the entry with the lowest index wins. Every in-flight entry ranks ahead of every completed entry.
- R5: A valid completed entry is a hazard only when its read-advance is negative and the elapsed cycles are fewer than the magnitude of the read-advance. Elapsed cycles are `cur_cycle_i` minus the write-back stamp, modulo 2^CNT_W. Its remaining wait is the magnitude minus the elapsed cycles, and it competes with the in-flight entries for the maximum.
- R6: If no entry yields a positive known wait and at least one valid, non-duplicate in-flight entry has its unknown flag set, the outputs are `hazard_o`=1, `unknown_o`=1 and `cycles_o`=0. `reg_o` is the register of the lowest-indexed such entry.
- R7: A positive known wait from any entry, in-flight or completed, overrides an unknown-latency entry, whatever the index order.
- R8: A valid in-flight entry whose tag equals the tag of a valid in-flight entry at a lower index is ignored. Only the first copy of a write counts, including whether it is of unknown latency. Invalid entries never suppress a later one.
- R9: Entries whose valid bit is 0 have no effect on any output.
- R10: When there is no hazard, `hazard_o`, `unknown_o`, `cycles_o` and `reg_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Evaluate the presented entries this cycle |
| cur_cycle_i | input | CNT_W | Current cycle count |
| infl_valid_i | input | NI | In-flight entry valid bits |
| infl_unknown_i | input | NI | In-flight entry latency unknown |
| infl_cycles_i | input | NI*CL_W | Signed cycles-left per in-flight entry, entry i at [i*CL_W +: CL_W] |
| infl_adv_i | input | NI*AD_W | Signed read-advance per in-flight entry |
| infl_tag_i | input | NI*TAG_W | Write identity per in-flight entry |
| infl_reg_i | input | NI*REG_W | Register ID of the in-flight write |
| done_valid_i | input | ND | Completed entry valid bits |
| done_wb_i | input | ND*CNT_W | Write-back cycle stamp per completed entry |
| done_adv_i | input | ND*AD_W | Signed read-advance per completed entry |
| done_reg_i | input | ND*REG_W | Register ID of the completed write |
| done_o | output | 1 | Result updated this cycle |
| hazard_o | output | 1 | Read must wait |
| unknown_o | output | 1 | Wait length is unknown |
| cycles_o | output | RES_W | Remaining cycles (max(CL_W,AD_W)+1 bits) |
| reg_o | output | REG_W | Register causing the stall |

## Verification
The assertions assume that `start_i` is a clean synchronous level and that entry fields are meaningful only where the matching valid bit is set. They also assume that duplicate tags may carry values different from their first copy, and the rule that the first copy wins has to hold even then. The stimulus drives every input half a cycle away from the sampling edge. It sweeps tags over a small range so that duplicates are frequent, and it places write-back stamps within a few cycles of the current count, including across the counter wrap. Cycles-left and read-advance values are drawn from ranges that cover positive, zero and negative differences.

// File: rtl/raw_pkg.sv
package raw_pkg;
  typedef enum logic [1:0] {
    RK_NONE    = 2'd0,
    RK_KNOWN   = 2'd1,
    RK_UNKNOWN = 2'd2
  } res_kind_e;

  function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/raw_infl_eval.sv
module raw_infl_eval #(
  parameter int unsigned CL_W  = 8,
  parameter int unsigned AD_W  = 8,
  parameter int unsigned RES_W = 9
) (
  input  logic             valid_i,
  input  logic             unknown_i,
  input  logic             dup_i,
  input  logic [CL_W-1:0]  cycles_i,
  input  logic [AD_W-1:0]  adv_i,
  output logic             hit_o,
  output logic             unk_o,
  output logic [RES_W-1:0] rem_o
);
  logic signed [RES_W-1:0] cl_x, ad_x, diff;
  logic live;

  assign live = valid_i && !dup_i;
  assign cl_x = RES_W'($signed(cycles_i));
  assign ad_x = RES_W'($signed(adv_i));
  assign diff = cl_x - ad_x;

  assign hit_o = live && !unknown_i && !diff[RES_W-1] && (diff != '0);
  assign unk_o = live && unknown_i;
  assign rem_o = diff;
endmodule

// File: rtl/raw_done_eval.sv
module raw_done_eval #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned AD_W  = 8,
  parameter int unsigned RES_W = 9
) (
  input  logic             valid_i,
  input  logic [CNT_W-1:0] wb_i,
  input  logic [AD_W-1:0]  adv_i,
  input  logic [CNT_W-1:0] cur_i,
  output logic             hit_o,
  output logic [RES_W-1:0] rem_o
);
  localparam int unsigned CW = raw_pkg::wmax(CNT_W, AD_W) + 1;

  logic [CNT_W-1:0] elapsed;
  logic [AD_W:0]    neg_adv;
  logic [CW-1:0]    el_x, mag_x, left;

  assign elapsed = cur_i - wb_i;
  assign neg_adv = '0 - {adv_i[AD_W-1], adv_i};
  assign el_x    = CW'(elapsed);
  assign mag_x   = CW'(neg_adv[AD_W-1:0]);
  assign left    = mag_x - el_x;

  // magnitude of a negative AD_W-bit value fits in AD_W unsigned bits
  assign hit_o = valid_i && adv_i[AD_W-1] && (el_x < mag_x);
  assign rem_o = RES_W'(left);
endmodule

// File: rtl/raw_max_sel.sv
module raw_max_sel #(
  parameter int unsigned N     = 8,
  parameter int unsigned RES_W = 9,
  parameter int unsigned REG_W = 6
) (
  input  logic [N-1:0]       hit_i,
  input  logic [N*RES_W-1:0] rem_i,
  input  logic [N*REG_W-1:0] reg_i,
  output logic               hit_o,
  output logic [RES_W-1:0]   rem_o,
  output logic [REG_W-1:0]   reg_o
);
  always_comb begin
    hit_o = 1'b0;
    rem_o = '0;
    reg_o = '0;
    // strict compare keeps the lowest index on ties
    for (int i = 0; i < N; i++) begin
      if (hit_i[i] && (!hit_o || (rem_i[i*RES_W +: RES_W] > rem_o))) begin
        hit_o = 1'b1;
        rem_o = rem_i[i*RES_W +: RES_W];
        reg_o = reg_i[i*REG_W +: REG_W];
      end
    end
  end
endmodule

// File: rtl/raw_hazard_calc.sv
module raw_hazard_calc #(
  parameter int unsigned NI    = 4,
  parameter int unsigned ND    = 4,
  parameter int unsigned CL_W  = 8,
  parameter int unsigned AD_W  = 8,
  parameter int unsigned TAG_W = 2,
  parameter int unsigned REG_W = 6,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned RES_W = raw_pkg::wmax(CL_W, AD_W) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    cur_cycle_i,
  input  logic [NI-1:0]       infl_valid_i,
  input  logic [NI-1:0]       infl_unknown_i,
  input  logic [NI*CL_W-1:0]  infl_cycles_i,
  input  logic [NI*AD_W-1:0]  infl_adv_i,
  input  logic [NI*TAG_W-1:0] infl_tag_i,
  input  logic [NI*REG_W-1:0] infl_reg_i,
  input  logic [ND-1:0]       done_valid_i,
  input  logic [ND*CNT_W-1:0] done_wb_i,
  input  logic [ND*AD_W-1:0]  done_adv_i,
  input  logic [ND*REG_W-1:0] done_reg_i,
  output logic                done_o,
  output logic                hazard_o,
  output logic                unknown_o,
  output logic [RES_W-1:0]    cycles_o,
  output logic [REG_W-1:0]    reg_o
);
  import raw_pkg::*;

  localparam int unsigned NC = NI + ND;

  logic [NC-1:0]       cand_hit;
  logic [NC*RES_W-1:0] cand_rem;
  logic [NC*REG_W-1:0] cand_reg;
  logic [NI-1:0]       infl_unk;

  for (genvar i = 0; i < NI; i++) begin : g_infl
    logic dup;
    always_comb begin
      dup = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (infl_valid_i[j] &&
            infl_tag_i[j*TAG_W +: TAG_W] == infl_tag_i[i*TAG_W +: TAG_W])
          dup = 1'b1;
      end
    end

    raw_infl_eval #(.CL_W(CL_W), .AD_W(AD_W), .RES_W(RES_W)) i_eval (
      .valid_i  (infl_valid_i[i]),
      .unknown_i(infl_unknown_i[i]),
      .dup_i    (dup),
      .cycles_i (infl_cycles_i[i*CL_W +: CL_W]),
      .adv_i    (infl_adv_i[i*AD_W +: AD_W]),
      .hit_o    (cand_hit[i]),
      .unk_o    (infl_unk[i]),
      .rem_o    (cand_rem[i*RES_W +: RES_W])
    );
  end

  for (genvar k = 0; k < ND; k++) begin : g_done
    raw_done_eval #(.CNT_W(CNT_W), .AD_W(AD_W), .RES_W(RES_W)) i_eval (
      .valid_i(done_valid_i[k]),
      .wb_i   (done_wb_i[k*CNT_W +: CNT_W]),
      .adv_i  (done_adv_i[k*AD_W +: AD_W]),
      .cur_i  (cur_cycle_i),
      .hit_o  (cand_hit[NI+k]),
      .rem_o  (cand_rem[(NI+k)*RES_W +: RES_W])
    );
  end

  // in-flight entries occupy the low candidate slots, so they rank first
  assign cand_reg = {done_reg_i, infl_reg_i};

  logic             best_hit;
  logic [RES_W-1:0] best_rem;
  logic [REG_W-1:0] best_reg;

  raw_max_sel #(.N(NC), .RES_W(RES_W), .REG_W(REG_W)) i_max (
    .hit_i(cand_hit),
    .rem_i(cand_rem),
    .reg_i(cand_reg),
    .hit_o(best_hit),
    .rem_o(best_rem),
    .reg_o(best_reg)
  );

  logic [REG_W-1:0] unk_reg;
  always_comb begin
    unk_reg = '0;
    for (int i = NI - 1; i >= 0; i--) begin
      if (infl_unk[i]) unk_reg = infl_reg_i[i*REG_W +: REG_W];
    end
  end

  res_kind_e kind;
  always_comb begin
    if (best_hit)        kind = RK_KNOWN;
    else if (|infl_unk)  kind = RK_UNKNOWN;
    else                 kind = RK_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      hazard_o  <= 1'b0;
      unknown_o <= 1'b0;
      cycles_o  <= '0;
      reg_o     <= '0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        hazard_o  <= (kind != RK_NONE);
        unknown_o <= (kind == RK_UNKNOWN);
        cycles_o  <= (kind == RK_KNOWN) ? best_rem : '0;
        case (kind)
          RK_KNOWN:   reg_o <= best_reg;
          RK_UNKNOWN: reg_o <= unk_reg;
          default:    reg_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/raw_hazard_calc_chk.sv
module raw_hazard_calc_chk #(
  parameter int unsigned NI    = 4,
  parameter int unsigned ND    = 4,
  parameter int unsigned RES_W = 9,
  parameter int unsigned REG_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [NI-1:0]    infl_valid_i,
  input logic [ND-1:0]    done_valid_i,
  input logic             done_o,
  input logic             hazard_o,
  input logic             unknown_o,
  input logic [RES_W-1:0] cycles_o,
  input logic [REG_W-1:0] reg_o
);
  // R2
  done_follows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  // R2
  done_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  // R2
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(hazard_o) && $stable(unknown_o) && $stable(cycles_o) && $stable(reg_o)));

  // R3
  known_positive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hazard_o && !unknown_o) |-> (cycles_o != '0));

  // R6
  unknown_zero_cycles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unknown_o |-> (hazard_o && cycles_o == '0));

  // R10
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hazard_o |-> (!unknown_o && cycles_o == '0 && reg_o == '0));

  // R9
  no_entries_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && infl_valid_i == '0 && done_valid_i == '0) |=> !hazard_o);
endmodule

bind raw_hazard_calc raw_hazard_calc_chk #(
  .NI(NI), .ND(ND), .RES_W(RES_W), .REG_W(REG_W)
) i_raw_hazard_calc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .infl_valid_i(infl_valid_i),
  .done_valid_i(done_valid_i),
  .done_o      (done_o),
  .hazard_o    (hazard_o),
  .unknown_o   (unknown_o),
  .cycles_o    (cycles_o),
  .reg_o       (reg_o)
);

// File: tb/test_raw_hazard_calc.sv
`timescale 1ns/1ps
module test_raw_hazard_calc;
  localparam int NI = 4, ND = 4, CL_W = 8, AD_W = 8, TAG_W = 2, REG_W = 6, CNT_W = 16;
  localparam int RES_W = 9;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [CNT_W-1:0]    cur_cycle_i = '0;
  logic [NI-1:0]       infl_valid_i = '0, infl_unknown_i = '0;
  logic [NI*CL_W-1:0]  infl_cycles_i = '0;
  logic [NI*AD_W-1:0]  infl_adv_i = '0;
  logic [NI*TAG_W-1:0] infl_tag_i = '0;
  logic [NI*REG_W-1:0] infl_reg_i = '0;
  logic [ND-1:0]       done_valid_i = '0;
  logic [ND*CNT_W-1:0] done_wb_i = '0;
  logic [ND*AD_W-1:0]  done_adv_i = '0;
  logic [ND*REG_W-1:0] done_reg_i = '0;
  logic done_o, hazard_o, unknown_o;
  logic [RES_W-1:0] cycles_o;
  logic [REG_W-1:0] reg_o;

  raw_hazard_calc i_raw_hazard_calc (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  int iv[NI], iu[NI], icl[NI], iad[NI], itag[NI], ireg[NI];
  int dv[ND], dwb[ND], dad[ND], dreg[ND];
  int cur;

  task automatic clear_vec();
    for (int i = 0; i < NI; i++) begin
      iv[i] = 0; iu[i] = 0; icl[i] = 0; iad[i] = 0; itag[i] = i; ireg[i] = 0;
    end
    for (int k = 0; k < ND; k++) begin
      dv[k] = 0; dwb[k] = 0; dad[k] = 0; dreg[k] = 0;
    end
    cur = 0;
  endtask

  task automatic drive_vec();
    for (int i = 0; i < NI; i++) begin
      infl_valid_i[i]   = iv[i][0];
      infl_unknown_i[i] = iu[i][0];
      infl_cycles_i[i*CL_W +: CL_W] = icl[i][CL_W-1:0];
      infl_adv_i[i*AD_W +: AD_W]    = iad[i][AD_W-1:0];
      infl_tag_i[i*TAG_W +: TAG_W]  = itag[i][TAG_W-1:0];
      infl_reg_i[i*REG_W +: REG_W]  = ireg[i][REG_W-1:0];
    end
    for (int k = 0; k < ND; k++) begin
      done_valid_i[k] = dv[k][0];
      done_wb_i[k*CNT_W +: CNT_W]  = dwb[k][CNT_W-1:0];
      done_adv_i[k*AD_W +: AD_W]   = dad[k][AD_W-1:0];
      done_reg_i[k*REG_W +: REG_W] = dreg[k][REG_W-1:0];
    end
    cur_cycle_i = cur[CNT_W-1:0];
  endtask

  int e_h, e_u, e_c, e_r;
  task automatic model();
    int best, breg, uf, ureg;
    best = 0; breg = 0; uf = 0; ureg = 0;
    for (int i = 0; i < NI; i++) begin
      bit dup;
      dup = 0;
      for (int j = 0; j < i; j++) if (iv[j] != 0 && itag[j] == itag[i]) dup = 1;
      if (iv[i] != 0 && !dup) begin
        if (iu[i] != 0) begin
          if (uf == 0) begin uf = 1; ureg = ireg[i]; end
        end else if (icl[i] - iad[i] > best) begin
          best = icl[i] - iad[i]; breg = ireg[i];
        end
      end
    end
    for (int k = 0; k < ND; k++) begin
      if (dv[k] != 0 && dad[k] < 0) begin
        int el;
        el = (cur - dwb[k]) & 32'hFFFF;
        if (el < -dad[k] && (-dad[k] - el) > best) begin
          best = -dad[k] - el; breg = dreg[k];
        end
      end
    end
    if (best > 0) begin e_h = 1; e_u = 0; e_c = best; e_r = breg; end
    else if (uf != 0) begin e_h = 1; e_u = 1; e_c = 0; e_r = ureg; end
    else begin e_h = 0; e_u = 0; e_c = 0; e_r = 0; end
  endtask

  task automatic compare(string rq, int dn);
    checks++;
    if (done_o !== dn[0] || hazard_o !== e_h[0] || unknown_o !== e_u[0] ||
        cycles_o !== e_c[RES_W-1:0] || reg_o !== e_r[REG_W-1:0]) begin
      fails++;
      $display("FAIL %s: got done=%0b haz=%0b unk=%0b cyc=%0d reg=%0d exp done=%0b haz=%0d unk=%0d cyc=%0d reg=%0d",
               rq, done_o, hazard_o, unknown_o, cycles_o, reg_o, dn[0], e_h, e_u, e_c, e_r);
    end
  endtask

  // present vector, strobe start, check result one edge later
  task automatic run(string rq);
    @(negedge clk_i);
    drive_vec();
    model();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    compare(rq, 1);
  endtask

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clear_vec();
    drive_vec();
    repeat (3) @(negedge clk_i);
    e_h = 0; e_u = 0; e_c = 0; e_r = 0;
    compare("R1 in reset", 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 after reset", 0);

    // R9 R10: all invalid, fields populated
    clear_vec();
    icl[0] = 50; ireg[0] = 9; iu[1] = 1; ireg[1] = 4; dad[0] = -9; dwb[0] = 0; dreg[0] = 7;
    run("R9 invalid entries");

    // R3: maximum of adjusted waits
    clear_vec();
    iv[0] = 1; icl[0] = 5; iad[0] = 1; ireg[0] = 7;
    iv[1] = 1; icl[1] = 9; iad[1] = 0; ireg[1] = 3;
    iv[2] = 1; icl[2] = 3; iad[2] = -4; ireg[2] = 8;
    run("R3 max wait");

    // R3 R10: zero and negative results ignored
    clear_vec();
    iv[0] = 1; icl[0] = 2; iad[0] = 2; ireg[0] = 5;
    iv[1] = 1; icl[1] = 1; iad[1] = 3; ireg[1] = 6;
    run("R10 non-positive");

    // R3: extreme signed operands
    clear_vec();
    iv[3] = 1; icl[3] = 127; iad[3] = -128; ireg[3] = 63;
    run("R3 widest difference");

    // R4: ties
    clear_vec();
    iv[0] = 1; icl[0] = 4; ireg[0] = 10;
    iv[2] = 1; icl[2] = 4; ireg[2] = 20;
    dv[0] = 1; dad[0] = -4; dwb[0] = 5; cur = 5; dreg[0] = 30;
    run("R4 tie order");
    clear_vec();
    dv[1] = 1; dad[1] = -6; dwb[1] = 10; cur = 12; dreg[1] = 21;
    dv[3] = 1; dad[3] = -5; dwb[3] = 11; dreg[3] = 22;
    run("R4 completed tie");

    // R5: completed writes
    clear_vec();
    dv[0] = 1; dad[0] = -5; dwb[0] = 100; cur = 102; dreg[0] = 11;
    run("R5 negative advance");
    dwb[0] = 97;
    run("R5 boundary elapsed");
    clear_vec();
    dv[2] = 1; dad[2] = -4; dwb[2] = 16'hFFFF; cur = 1; dreg[2] = 12;
    run("R5 counter wrap");
    clear_vec();
    dv[1] = 1; dad[1] = 3; dwb[1] = 50; cur = 50; dreg[1] = 13;
    run("R5 non-negative advance");

    // R6: unknown latency
    clear_vec();
    iv[1] = 1; iu[1] = 1; ireg[1] = 12;
    iv[3] = 1; iu[3] = 1; ireg[3] = 13;
    iv[0] = 1; icl[0] = 1; iad[0] = 1; ireg[0] = 14;
    run("R6 first unknown");

    // R7: known overrides unknown
    clear_vec();
    iv[0] = 1; iu[0] = 1; ireg[0] = 12;
    iv[2] = 1; icl[2] = 3; ireg[2] = 15;
    run("R7 in-flight override");
    clear_vec();
    iv[0] = 1; iu[0] = 1; ireg[0] = 12;
    dv[3] = 1; dad[3] = -2; dwb[3] = 7; cur = 7; dreg[3] = 16;
    run("R7 completed override");

    // R8: duplicates
    clear_vec();
    iv[0] = 1; itag[0] = 1; icl[0] = 2; ireg[0] = 5;
    iv[1] = 1; itag[1] = 1; icl[1] = 9; ireg[1] = 6;
    run("R8 duplicate ignored");
    clear_vec();
    iv[0] = 0; itag[0] = 1; icl[0] = 2; ireg[0] = 5;
    iv[1] = 1; itag[1] = 1; icl[1] = 9; ireg[1] = 6;
    run("R8 invalid does not suppress");
    clear_vec();
    iv[0] = 1; itag[0] = 2; iu[0] = 1; ireg[0] = 17;
    iv[1] = 1; itag[1] = 2; icl[1] = 5; ireg[1] = 18;
    run("R8 duplicate of unknown");

    // R2: hold without start
    clear_vec();
    iv[0] = 1; icl[0] = 6; ireg[0] = 19;
    run("R2 load");
    clear_vec();
    iv[0] = 1; icl[0] = 40; ireg[0] = 2;
    @(negedge clk_i);
    drive_vec();
    @(negedge clk_i);
    @(negedge clk_i);
    e_h = 1; e_u = 0; e_c = 6; e_r = 19;
    compare("R2 hold", 0);

    // sweep
    for (int n = 0; n < 3000; n++) begin
      clear_vec();
      cur = $urandom_range(0, 65535);
      for (int i = 0; i < NI; i++) begin
        iv[i] = $urandom_range(0, 3) != 0;
        iu[i] = $urandom_range(0, 7) == 0;
        icl[i] = $urandom_range(0, 16) - 4;
        iad[i] = $urandom_range(0, 12) - 6;
        itag[i] = $urandom_range(0, 3);
        ireg[i] = $urandom_range(1, 63);
      end
      for (int k = 0; k < ND; k++) begin
        dv[k] = $urandom_range(0, 1);
        dad[k] = $urandom_range(0, 11) - 8;
        dwb[k] = (cur - $urandom_range(0, 8)) & 32'hFFFF;
        dreg[k] = $urandom_range(1, 63);
      end
      run("R3 R4 R5 R6 R7 R8 sweep");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule